// File: doc/BRIEF.md
# Standby Power Mode Controller

This block sequences clock gating and oscillator enables for a small microcontroller that can idle in one of two standby levels. When the CPU issues a wait-for-interrupt request, a mode select bit picks the level. The light level stops only the CPU clock and leaves every oscillator as software left it. The deep level also turns off both high-speed oscillators, so the whole system clock stops. An interrupt request brings the block back to normal operation. The interrupt passes through a two-flop synchronizer first.

The deep level is not allowed while the CPU runs from the secondary clock. In that case a deep request falls back to the light level and sets a sticky flag. If the main clock comes from the external crystal, leaving the deep level inserts a stabilization wait before the CPU clock is released. The wait is 2^N ticks of the low-speed oscillator, with N taken from a programmable exponent. A strap input, sampled while reset is held, decides whether the low-speed oscillator runs during standby.

Top module: `stby_top`

## Requirements
- R1: While reset is released, the block is in normal run: modeCode = 2'b00, cpuClkEn = 1, lsEn = 1 and deepRefused = 0.
- R2: A wfiReq pulse with deepSel = 0 enters light sleep on that clock edge: modeCode = 2'b01, cpuClkEn = 0, hsxEn = hsxOn and hsiEn = hsiOn.
- R3: A wfiReq pulse with deepSel = 1 and onSubClk = 0 enters deep sleep: modeCode = 2'b10, cpuClkEn = 0, hsxEn = 0 and hsiEn = 0.
- R4: lsEn is 1 outside standby. In either standby mode lsEn equals the value that lsKeepCfg had while rstN was low. Changes to lsKeepCfg after reset have no effect.
- R5: Waking from light sleep, or from deep sleep with mainIsXtal = 0, is triggered by irqAsync going high. The two-flop synchronizer and a one-cycle resume step mean cpuClkEn returns on the 4th rising edge after the rise. During the cycle before that edge, modeCode = 2'b11.
- R6: Waking from deep sleep with mainIsXtal = 1 loads a counter with 2^N, where N is stabExp clamped to the range 8..18. The counter decrements only on clock edges where lsTick = 1. The block resumes after the counter reaches zero. If lsTick is low for the first h edges and high afterwards, cpuClkEn returns on edge max(4, h+1) + 2^N + 1. During the wait, hsxEn = 1, lsEn = 1 and modeCode = 2'b11.
- R7: A deep request made while onSubClk = 1 enters light sleep instead (modeCode = 2'b01) and sets deepRefused. deepRefused stays set until the next reset.
- R8: If the synchronized interrupt is already high when wfiReq arrives, the request is dropped and the block stays in run (modeCode = 2'b00, cpuClkEn = 1).
- R9: cpuClkEn is high only while modeCode = 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wfiReq | input | 1 | One-cycle wait-for-interrupt request from the CPU |
| deepSel | input | 1 | 1 selects deep sleep for the next request |
| onSubClk | input | 1 | 1 while the CPU runs from the secondary clock |
| mainIsXtal | input | 1 | 1 when the main clock source is the external crystal |
| hsxOn | input | 1 | Software enable for the high-speed external oscillator |
| hsiOn | input | 1 | Software enable for the high-speed internal oscillator |
| lsKeepCfg | input | 1 | Strap sampled during reset: keep the low-speed oscillator in standby |
| stabExp | input | 5 | Stabilization exponent N (clamped to 8..18) |
| lsTick | input | 1 | One-cycle tick from the low-speed oscillator |
| irqAsync | input | 1 | Asynchronous wake interrupt request |
| hsxEn | output | 1 | High-speed external oscillator enable |
| hsiEn | output | 1 | High-speed internal oscillator enable |
| lsEn | output | 1 | Low-speed oscillator enable |
| cpuClkEn | output | 1 | CPU clock gate enable |
| modeCode | output | 2 | 00 run, 01 light sleep, 10 deep sleep, 11 waking |
| deepRefused | output | 1 | Sticky: a deep request was downgraded |

## Verification
The hardest case to reach from the ports is a wake from deep sleep on the crystal while the low-speed tick is absent. Here the release cycle depends on the tick history, not on elapsed cycles. The stimulus reaches it by holding lsTick low for a random number of edges after the interrupt rises, then raising it. The bench measures the cycle on which cpuClkEn returns and compares it with the formula in R6. The abort case needs the interrupt already synchronized before the request arrives. To get there, the bench raises irqAsync, waits three edges, and then pulses wfiReq.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_DEEP   = 3'd2,
    ST_STAB   = 3'd3,
    ST_RESUME = 3'd4
  } stbyState_e;

  typedef struct packed {
    logic loadWait;
    logic runWait;
    logic flagRefused;
  } ctlStrobe_t;

  localparam logic [1:0] MODE_RUN   = 2'b00;
  localparam logic [1:0] MODE_SLEEP = 2'b01;
  localparam logic [1:0] MODE_DEEP  = 2'b10;
  localparam logic [1:0] MODE_WAKE  = 2'b11;
endpackage

// File: rtl/stby_datapath.sv
module stby_datapath
  import stby_pkg::*;
#(
  parameter int EXP_W   = 5,
  parameter int EXP_MIN = 8,
  parameter int EXP_MAX = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqAsync,
  input  logic             lsTick,
  input  logic             lsKeepCfg,
  input  logic [EXP_W-1:0] stabExp,
  input  ctlStrobe_t       strobe,
  output logic             irqSync,
  output logic             waitDone,
  output logic             lsKeep,
  output logic             deepRefused
);
  localparam int CNT_W = EXP_MAX + 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       waitCnt;
  logic [EXP_W-1:0]       nEff;
  logic [CNT_W-1:0]       loadVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], irqAsync};
  end
  assign irqSync = syncChain[SYNC_STAGES-1];

  always_comb begin
    if (stabExp < EXP_W'(EXP_MIN))      nEff = EXP_W'(EXP_MIN);
    else if (stabExp > EXP_W'(EXP_MAX)) nEff = EXP_W'(EXP_MAX);
    else                                nEff = stabExp;
    loadVal = {{(CNT_W-1){1'b0}}, 1'b1} << nEff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitCnt <= '0;
    else if (strobe.loadWait) waitCnt <= loadVal;
    else if (strobe.runWait && lsTick && (waitCnt != '0)) waitCnt <= waitCnt - 1'b1;
  end
  assign waitDone = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lsKeep <= lsKeepCfg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) deepRefused <= 1'b0;
    else if (strobe.flagRefused) deepRefused <= 1'b1;
  end
endmodule

// File: rtl/stby_control.sv
module stby_control
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wfiReq,
  input  logic       deepSel,
  input  logic       onSubClk,
  input  logic       mainIsXtal,
  input  logic       hsxOn,
  input  logic       hsiOn,
  input  logic       lsKeep,
  input  logic       irqSync,
  input  logic       waitDone,
  output ctlStrobe_t strobe,
  output logic       hsxEn,
  output logic       hsiEn,
  output logic       lsEn,
  output logic       cpuClkEn,
  output logic [1:0] modeCode
);
  stbyState_e curState, nextState;
  logic wantDeep;

  assign wantDeep = deepSel && !onSubClk;

  always_comb begin
    nextState = curState;
    strobe    = '0;
    unique case (curState)
      ST_RUN: begin
        if (wfiReq && !irqSync) begin
          nextState = wantDeep ? ST_DEEP : ST_SLEEP;
          strobe.flagRefused = deepSel && onSubClk;
        end
      end
      ST_SLEEP: if (irqSync) nextState = ST_RESUME;
      ST_DEEP: begin
        if (irqSync) begin
          if (mainIsXtal) begin
            nextState = ST_STAB;
            strobe.loadWait = 1'b1;
          end else begin
            nextState = ST_RESUME;
          end
        end
      end
      ST_STAB: begin
        strobe.runWait = 1'b1;
        if (waitDone) nextState = ST_RESUME;
      end
      ST_RESUME: nextState = ST_RUN;
      default:   nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_RUN;
    else       curState <= nextState;
  end

  always_comb begin
    hsxEn    = hsxOn;
    hsiEn    = hsiOn;
    lsEn     = 1'b1;
    cpuClkEn = 1'b0;
    modeCode = MODE_WAKE;
    unique case (curState)
      ST_RUN: begin
        cpuClkEn = 1'b1;
        modeCode = MODE_RUN;
      end
      ST_SLEEP: begin
        lsEn     = lsKeep;
        modeCode = MODE_SLEEP;
      end
      ST_DEEP: begin
        hsxEn    = 1'b0;
        hsiEn    = 1'b0;
        lsEn     = lsKeep;
        modeCode = MODE_DEEP;
      end
      ST_STAB:   hsxEn = 1'b1;
      ST_RESUME: modeCode = MODE_WAKE;
      default:   modeCode = MODE_WAKE;
    endcase
  end
endmodule

// File: rtl/stby_top.sv
module stby_top
  import stby_pkg::*;
#(
  parameter int EXP_W   = 5,
  parameter int EXP_MIN = 8,
  parameter int EXP_MAX = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wfiReq,
  input  logic             deepSel,
  input  logic             onSubClk,
  input  logic             mainIsXtal,
  input  logic             hsxOn,
  input  logic             hsiOn,
  input  logic             lsKeepCfg,
  input  logic [EXP_W-1:0] stabExp,
  input  logic             lsTick,
  input  logic             irqAsync,
  output logic             hsxEn,
  output logic             hsiEn,
  output logic             lsEn,
  output logic             cpuClkEn,
  output logic [1:0]       modeCode,
  output logic             deepRefused
);
  ctlStrobe_t strobe;
  logic irqSync, waitDone, lsKeep;

  stby_datapath #(
    .EXP_W(EXP_W), .EXP_MIN(EXP_MIN), .EXP_MAX(EXP_MAX), .SYNC_STAGES(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqAsync(irqAsync), .lsTick(lsTick),
    .lsKeepCfg(lsKeepCfg), .stabExp(stabExp), .strobe(strobe),
    .irqSync(irqSync), .waitDone(waitDone), .lsKeep(lsKeep),
    .deepRefused(deepRefused)
  );

  stby_control u_ctl (
    .clk(clk), .rstN(rstN), .wfiReq(wfiReq), .deepSel(deepSel),
    .onSubClk(onSubClk), .mainIsXtal(mainIsXtal), .hsxOn(hsxOn),
    .hsiOn(hsiOn), .lsKeep(lsKeep), .irqSync(irqSync), .waitDone(waitDone),
    .strobe(strobe), .hsxEn(hsxEn), .hsiEn(hsiEn), .lsEn(lsEn),
    .cpuClkEn(cpuClkEn), .modeCode(modeCode)
  );
endmodule

// File: rtl/stby_checker.sv
module stby_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wfiReq,
  input logic       onSubClk,
  input logic       hsxOn,
  input logic       hsiOn,
  input logic       irqSync,
  input logic       hsxEn,
  input logic       hsiEn,
  input logic       lsEn,
  input logic       cpuClkEn,
  input logic [1:0] modeCode,
  input logic       deepRefused
);
  a_r2_sleep_keeps_osc: assert property (@(posedge clk) disable iff (!rstN)
    modeCode == 2'b01 |-> (hsxEn == hsxOn) && (hsiEn == hsiOn));

  a_r3_deep_hs_off: assert property (@(posedge clk) disable iff (!rstN)
    modeCode == 2'b10 |-> !hsxEn && !hsiEn);

  a_r4_ls_on_in_run: assert property (@(posedge clk) disable iff (!rstN)
    modeCode == 2'b00 |-> lsEn);

  a_r7_no_deep_on_sub: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 2'b00 && wfiReq && onSubClk) |=> modeCode != 2'b10);

  a_r7_refused_sticky: assert property (@(posedge clk) disable iff (!rstN)
    deepRefused |=> deepRefused);

  a_r8_pending_abort: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 2'b00 && irqSync && wfiReq) |=> modeCode == 2'b00);

  a_r9_clk_only_run: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> modeCode == 2'b00);
endmodule

bind stby_top stby_checker u_chk (
  .clk(clk), .rstN(rstN), .wfiReq(wfiReq), .onSubClk(onSubClk),
  .hsxOn(hsxOn), .hsiOn(hsiOn), .irqSync(irqSync), .hsxEn(hsxEn),
  .hsiEn(hsiEn), .lsEn(lsEn), .cpuClkEn(cpuClkEn), .modeCode(modeCode),
  .deepRefused(deepRefused)
);

// File: tb/stby_top_tb.sv
`timescale 1ns/1ps
module stby_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wfiReq = 1'b0, deepSel = 1'b0, onSubClk = 1'b0, mainIsXtal = 1'b0;
  logic hsxOn = 1'b1, hsiOn = 1'b1, lsKeepCfg = 1'b0, lsTick = 1'b1, irqAsync = 1'b0;
  logic [4:0] stabExp = 5'd8;
  logic hsxEn, hsiEn, lsEn, cpuClkEn, deepRefused;
  logic [1:0] modeCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit expRefused = 1'b0;
  bit expLsKeep = 1'b0;

  always #2.5 clk = ~clk;

  stby_top u_dut (
    .clk(clk), .rstN(rstN), .wfiReq(wfiReq), .deepSel(deepSel),
    .onSubClk(onSubClk), .mainIsXtal(mainIsXtal), .hsxOn(hsxOn),
    .hsiOn(hsiOn), .lsKeepCfg(lsKeepCfg), .stabExp(stabExp),
    .lsTick(lsTick), .irqAsync(irqAsync), .hsxEn(hsxEn), .hsiEn(hsiEn),
    .lsEn(lsEn), .cpuClkEn(cpuClkEn), .modeCode(modeCode),
    .deepRefused(deepRefused)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampExp(input int e);
    if (e < 8) return 8;
    if (e > 18) return 18;
    return e;
  endfunction

  function automatic int wakeLatency(input bit deepXtal, input int e, input int hold);
    int first;
    if (!deepXtal) return 4;
    first = (hold + 1 > 4) ? hold + 1 : 4;
    return first + (1 << clampExp(e)) + 1;
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic doReset(input bit keep);
    @(negedge clk);
    rstN = 1'b0;
    lsKeepCfg = keep;
    irqAsync = 1'b0;
    wfiReq = 1'b0;
    cyc(3);
    rstN = 1'b1;
    lsKeepCfg = ~keep;
    expLsKeep = keep;
    expRefused = 1'b0;
    cyc(1);
    chk(modeCode == 2'b00, "R1 mode", modeCode, 0);
    chk(cpuClkEn == 1'b1, "R1 cpuClkEn", cpuClkEn, 1);
    chk(lsEn == 1'b1, "R1 lsEn", lsEn, 1);
    chk(deepRefused == 1'b0, "R1 deepRefused", deepRefused, 0);
  endtask

  task automatic episode(input bit dSel, input bit sub, input bit xtal,
                         input bit hx, input bit hi, input int e, input int hold);
    bit effDeep;
    int lat, expLat, prevMode;
    effDeep = dSel && !sub;
    deepSel = dSel; onSubClk = sub; mainIsXtal = xtal;
    hsxOn = hx | xtal; hsiOn = hi; stabExp = 5'(e);
    cyc(1);
    wfiReq = 1'b1;
    cyc(1);
    wfiReq = 1'b0;
    if (dSel && sub) expRefused = 1'b1;
    chk(modeCode == (effDeep ? 2'b10 : 2'b01), effDeep ? "R3 mode" : "R2 mode",
        modeCode, effDeep ? 2 : 1);
    chk(cpuClkEn == 1'b0, "R9 cpuClkEn in standby", cpuClkEn, 0);
    chk(hsxEn == (effDeep ? 1'b0 : hsxOn), effDeep ? "R3 hsxEn" : "R2 hsxEn",
        hsxEn, effDeep ? 0 : int'(hsxOn));
    chk(hsiEn == (effDeep ? 1'b0 : hsiOn), effDeep ? "R3 hsiEn" : "R2 hsiEn",
        hsiEn, effDeep ? 0 : int'(hsiOn));
    chk(lsEn == expLsKeep, "R4 lsEn in standby", lsEn, int'(expLsKeep));
    chk(deepRefused == expRefused, "R7 deepRefused", deepRefused, int'(expRefused));
    cyc($urandom % 5);
    expLat = wakeLatency(effDeep && xtal, e, hold);
    irqAsync = 1'b1;
    lat = -1;
    prevMode = int'(modeCode);
    for (int k = 1; k <= 3000; k++) begin
      lsTick = (k > hold);
      @(posedge clk);
      @(negedge clk);
      if (effDeep && xtal && k == expLat - 3) begin
        chk(hsxEn == 1'b1, "R6 hsxEn during wait", hsxEn, 1);
        chk(lsEn == 1'b1, "R6 lsEn during wait", lsEn, 1);
      end
      if (cpuClkEn) begin
        lat = k;
        break;
      end
      prevMode = int'(modeCode);
    end
    chk(lat == expLat, (effDeep && xtal) ? "R6 wake latency" : "R5 wake latency",
        lat, expLat);
    chk(prevMode == 3, "R5 waking mode code", prevMode, 3);
    irqAsync = 1'b0;
    lsTick = 1'b1;
    cyc(3);
    chk(modeCode == 2'b00 && cpuClkEn, "R9 back in run", modeCode, 0);
  endtask

  task automatic abortCase(input bit dSel);
    deepSel = dSel; onSubClk = 1'b0;
    irqAsync = 1'b1;
    cyc(3);
    wfiReq = 1'b1;
    cyc(1);
    wfiReq = 1'b0;
    chk(modeCode == 2'b00, "R8 abort mode", modeCode, 0);
    chk(cpuClkEn == 1'b1, "R8 abort cpuClkEn", cpuClkEn, 1);
    irqAsync = 1'b0;
    cyc(3);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    doReset(1'b0);
    episode(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8, 0);
    episode(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8, 0);
    episode(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3, 0);
    episode(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8, 53);
    episode(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 9, 0);
    abortCase(1'b1);
    abortCase(1'b0);
    episode(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8, 0);
    episode(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8, 0);
    chk(deepRefused == 1'b1, "R7 sticky after later sleep", deepRefused, 1);
    doReset(1'b1);
    episode(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8, 0);
    for (int i = 0; i < 24; i++) begin
      if (i % 8 == 7) doReset(1'($urandom % 2));
      episode(1'($urandom % 2), 1'($urandom % 4 == 0), 1'($urandom % 2),
              1'($urandom % 2), 1'($urandom % 2), int'($urandom % 11),
              int'($urandom % 40));
      if ($urandom % 6 == 0) abortCase(1'($urandom % 2));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule